// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Register Interface

This block is the host-facing digital side of a sigma-delta analog-to-digital converter. A host moves one bit per `bit_stb` pulse. Each transaction opens with an 8-bit command that picks one of eight register addresses, a direction and, for the data register, a streaming mode. The block holds the register file at the correct width for each address. It accepts write data most significant bit first and returns read data most significant bit first on the same serial output.

The serial output has a second role. Outside a read data phase it carries the active-low ready flag. A stub converter raises `conv_done` with a sample, an error flag and a channel number. The block latches these into the data and status registers and pulls the ready level low. Reading the data register to its last bit releases the ready level.

In continuous-read mode the block serves the data register by itself each time ready falls, and no new command is needed. A run of 32 one bits on the input resynchronises the interface, so it again expects a command.

Top module: `sdadc_serial_if`

## Requirements
- R1: A command byte is accepted only when its bit 7 is 0. Bit 6 set means read, bits 5:3 give the address and bit 2 asks for continuous read. A byte with bit 7 set is discarded and the next 8 bits are taken as a new command. Bit 2 has no effect on any address other than 3.
- R2: Data phases are 8 bits for addresses 0, 4 and 5, 16 bits for addresses 1 and 2, and 24 bits for addresses 3, 6 and 7. Data moves most significant bit first.
- R3: Writes to address 1 (mode), 2 (configuration), 5 (I/O), 6 (offset) and 7 (full-scale) are stored and read back unchanged. The reset values are 0x400A, 0x0710, 0x00, 0x800000 and 0x500000.
- R4: A write command to address 0, 3 or 4 has no data phase. The bits that follow are parsed as the next command, and no register changes.
- R5: Address 4 reads 0x4B, a fixed device code of 0xB in the low nibble.
- R6: The status word at address 0 reads as follows: bit 7 is the active-low ready flag, bit 6 is the error flag of the last accepted conversion, bits 5:3 are zero and bits 2:0 are that conversion's channel.
- R7: A conversion is accepted only while mode bits 15:13 hold 0 (continuous) or 1 (single). An accepted conversion latches data, error and channel and drives ready low on the next cycle. In idle (2) and the other modes it is ignored.
- R8: When a conversion is accepted in single mode, mode bits 15:13 become 2 (idle).
- R9: Ready returns high when the last bit of a data-register read is shifted. A status read leaves it unchanged.
- R10: Outside a read data phase, `sdo` equals the active-low ready flag. The flag is high after reset.
- R11: Command 0x5C enters continuous read. From then on, each time ready is low, 24 data bits are served with no command. The byte 0x58, sent while ready is high, leaves this mode.
- R12: The 32nd consecutive one on `sdi` returns the parser to waiting for a command and ends continuous read. Register contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One serial bit is transferred in this cycle |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data; ready flag (active low) between reads |
| conv_done | input | 1 | One-cycle pulse: converter has a new sample |
| conv_data | input | 24 | Sample value |
| conv_err | input | 1 | Sample was out of range |
| conv_chan | input | 3 | Channel of the sample |
| mode_word | output | 16 | Current mode register contents |
| conf_word | output | 16 | Current configuration register contents |

## Verification
A bit given on a strobe takes effect at the clock edge that samples it. The first read bit and the ready level therefore show on `sdo` from the next cycle on. The bench samples `sdo` at the falling edge before each strobe, so each read bit is taken one full cycle after the edge that placed it. A conversion pulse moves `sdo` one edge later, and the bench checks it at the falling edge after that pulse. In continuous read the sample is loaded one edge after ready falls, and the bench waits one extra cycle before it clocks the 24 bits. Every expected word is pushed into the scoreboard before its transaction starts.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

    localparam int SD_WIDE  = 24;
    localparam int SD_MID   = 16;
    localparam int SD_BYTE  = 8;
    localparam int SD_CNT_W = $clog2(SD_WIDE + 1);
    localparam int SD_CH_W  = 3;

    typedef enum logic [2:0] {
        A_STAT  = 3'd0,
        A_MODE  = 3'd1,
        A_CONF  = 3'd2,
        A_DATA  = 3'd3,
        A_IDENT = 3'd4,
        A_IO    = 3'd5,
        A_OFFS  = 3'd6,
        A_FSCL  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WR,
        PH_RD,
        PH_CRWAIT
    } phase_e;

    typedef enum logic [2:0] {
        OM_CONT   = 3'd0,
        OM_SINGLE = 3'd1,
        OM_IDLE   = 3'd2,
        OM_PDOWN  = 3'd3
    } op_mode_e;

    typedef struct packed {
        logic      wen_n;
        logic      rd;
        reg_addr_e addr;
        logic      cread;
        logic [1:0] pad;
    } cmd_t;

    typedef struct packed {
        logic [SD_WIDE-1:0] data;
        logic               err;
        logic [SD_CH_W-1:0] chan;
    } conv_t;

    localparam logic [7:0] CMD_CREAD_EXIT = 8'h58;
    localparam int MODE_SEL_HI = 15;
    localparam int MODE_SEL_LO = 13;

    function automatic logic [SD_CNT_W-1:0] reg_bits(reg_addr_e a);
        case (a)
            A_STAT, A_IDENT, A_IO: return SD_CNT_W'(SD_BYTE);
            A_MODE, A_CONF:        return SD_CNT_W'(SD_MID);
            default:               return SD_CNT_W'(SD_WIDE);
        endcase
    endfunction

    function automatic logic writable(reg_addr_e a);
        return (a == A_MODE) || (a == A_CONF) || (a == A_IO) ||
               (a == A_OFFS) || (a == A_FSCL);
    endfunction

    function automatic logic [SD_WIDE-1:0] align_msb(logic [SD_WIDE-1:0] v, reg_addr_e a);
        return v << (SD_WIDE - int'(reg_bits(a)));
    endfunction

    function automatic logic conv_allowed(logic [2:0] sel);
        return (sel == OM_CONT) || (sel == OM_SINGLE);
    endfunction

endpackage

// File: rtl/sdadc_ones_det.sv
module sdadc_ones_det #(
    parameter int ONES_N = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic sdi,
    output logic hit
);
    localparam int CW = $clog2(ONES_N + 1);

    logic [CW-1:0] run;
    logic          at_limit;

    assign at_limit = (run == CW'(ONES_N - 1));
    assign hit      = bit_stb && sdi && at_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (bit_stb) begin
            if (!sdi || at_limit) run <= '0;
            else                  run <= run + CW'(1);
        end
    end
endmodule

// File: rtl/sdadc_regfile.sv
module sdadc_regfile
    import sdadc_pkg::*;
#(
    parameter logic [7:0]         ID_VAL   = 8'h4B,
    parameter logic [SD_MID-1:0]  MODE_RST = 16'h400A,
    parameter logic [SD_MID-1:0]  CONF_RST = 16'h0710,
    parameter logic [7:0]         IO_RST   = 8'h00,
    parameter logic [SD_WIDE-1:0] OFFS_RST = 24'h800000,
    parameter logic [SD_WIDE-1:0] FS_RST   = 24'h500000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_addr_e          wr_addr,
    input  logic [SD_WIDE-1:0] wr_data,
    input  reg_addr_e          rd_addr,
    output logic [SD_WIDE-1:0] rd_value,
    input  logic               data_taken,
    input  logic               conv_done,
    input  conv_t              conv_in,
    output logic               rdy_n,
    output logic [SD_MID-1:0]  mode_q,
    output logic [SD_MID-1:0]  conf_q
);
    logic [7:0]         io_q;
    logic [SD_WIDE-1:0] offs_q;
    logic [SD_WIDE-1:0] fs_q;
    conv_t              sample_q;
    logic               rdy_q;
    logic               accept;
    logic [2:0]         op_sel;

    assign op_sel = mode_q[MODE_SEL_HI:MODE_SEL_LO];
    assign accept = conv_done && conv_allowed(op_sel);
    assign rdy_n  = rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_RST;
            conf_q   <= CONF_RST;
            io_q     <= IO_RST;
            offs_q   <= OFFS_RST;
            fs_q     <= FS_RST;
            sample_q <= '0;
            rdy_q    <= 1'b1;
        end else begin
            if (accept) begin
                sample_q <= conv_in;
                rdy_q    <= 1'b0;
                if (op_sel == OM_SINGLE)
                    mode_q[MODE_SEL_HI:MODE_SEL_LO] <= OM_IDLE;
            end else if (data_taken) begin
                rdy_q <= 1'b1;
            end
            if (wr_en) begin
                case (wr_addr)
                    A_MODE:  mode_q <= wr_data[SD_MID-1:0];
                    A_CONF:  conf_q <= wr_data[SD_MID-1:0];
                    A_IO:    io_q   <= wr_data[7:0];
                    A_OFFS:  offs_q <= wr_data;
                    A_FSCL:  fs_q   <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_STAT:  rd_value = SD_WIDE'({rdy_q, sample_q.err, 3'b000, sample_q.chan});
            A_MODE:  rd_value = SD_WIDE'(mode_q);
            A_CONF:  rd_value = SD_WIDE'(conf_q);
            A_DATA:  rd_value = sample_q.data;
            A_IDENT: rd_value = SD_WIDE'(ID_VAL);
            A_IO:    rd_value = SD_WIDE'(io_q);
            A_OFFS:  rd_value = offs_q;
            default: rd_value = fs_q;
        endcase
    end
endmodule

// File: rtl/sdadc_cmd_parser.sv
module sdadc_cmd_parser
    import sdadc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_stb,
    input  logic               sdi,
    input  logic               if_reset,
    input  logic               rdy_n,
    input  logic [SD_WIDE-1:0] rd_value,
    output reg_addr_e          rd_addr,
    output logic               wr_en,
    output reg_addr_e          wr_addr,
    output logic [SD_WIDE-1:0] wr_data,
    output logic               data_taken,
    output logic               sdo,
    output logic               rd_active,
    output logic               cread_on
);
    phase_e              phase;
    logic [SD_CNT_W-1:0] cnt;
    logic [SD_WIDE-1:0]  shreg;
    reg_addr_e           cur_addr;
    logic                cread_q;

    cmd_t                cmd_in;
    logic [SD_WIDE-1:0]  shift_in;
    logic [SD_CNT_W-1:0] width_cur;
    logic                last_bit;
    logic                byte_end;

    assign cmd_in    = cmd_t'({shreg[6:0], sdi});
    assign shift_in  = {shreg[SD_WIDE-2:0], sdi};
    assign width_cur = reg_bits(cur_addr);
    assign last_bit  = (cnt == width_cur - SD_CNT_W'(1));
    assign byte_end  = (cnt == SD_CNT_W'(SD_BYTE - 1));

    assign rd_addr    = (phase == PH_CRWAIT) ? A_DATA : cmd_in.addr;
    assign wr_addr    = cur_addr;
    assign wr_data    = shift_in & ((SD_WIDE'(1) << width_cur) - SD_WIDE'(1));
    assign wr_en      = (phase == PH_WR) && bit_stb && last_bit && !if_reset;
    assign data_taken = (phase == PH_RD) && bit_stb && last_bit &&
                        (cur_addr == A_DATA) && !if_reset;
    assign sdo        = (phase == PH_RD) ? shreg[SD_WIDE-1] : rdy_n;
    assign rd_active  = (phase == PH_RD);
    assign cread_on   = cread_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            cnt      <= '0;
            shreg    <= '0;
            cur_addr <= A_STAT;
            cread_q  <= 1'b0;
        end else if (if_reset) begin
            phase   <= PH_CMD;
            cnt     <= '0;
            cread_q <= 1'b0;
        end else begin
            case (phase)
                PH_CMD: begin
                    if (bit_stb) begin
                        if (byte_end) begin
                            cnt <= '0;
                            if (!cmd_in.wen_n) begin
                                if (cmd_in.rd) begin
                                    if (cmd_in.addr == A_DATA && cmd_in.cread) begin
                                        cread_q <= 1'b1;
                                        phase   <= PH_CRWAIT;
                                    end else begin
                                        cur_addr <= cmd_in.addr;
                                        shreg    <= align_msb(rd_value, cmd_in.addr);
                                        phase    <= PH_RD;
                                    end
                                end else if (writable(cmd_in.addr)) begin
                                    cur_addr <= cmd_in.addr;
                                    phase    <= PH_WR;
                                end
                            end
                        end else begin
                            cnt   <= cnt + SD_CNT_W'(1);
                            shreg <= shift_in;
                        end
                    end
                end
                PH_WR: begin
                    if (bit_stb) begin
                        shreg <= shift_in;
                        if (last_bit) begin
                            cnt   <= '0;
                            phase <= PH_CMD;
                        end else begin
                            cnt <= cnt + SD_CNT_W'(1);
                        end
                    end
                end
                PH_RD: begin
                    if (bit_stb) begin
                        shreg <= {shreg[SD_WIDE-2:0], 1'b0};
                        if (last_bit) begin
                            cnt   <= '0;
                            phase <= cread_q ? PH_CRWAIT : PH_CMD;
                        end else begin
                            cnt <= cnt + SD_CNT_W'(1);
                        end
                    end
                end
                default: begin
                    if (cnt == '0 && !rdy_n) begin
                        cur_addr <= A_DATA;
                        shreg    <= align_msb(rd_value, A_DATA);
                        phase    <= PH_RD;
                    end else if (bit_stb) begin
                        if (byte_end) begin
                            cnt <= '0;
                            if ({shreg[6:0], sdi} == CMD_CREAD_EXIT) begin
                                cread_q <= 1'b0;
                                phase   <= PH_CMD;
                            end
                        end else begin
                            cnt   <= cnt + SD_CNT_W'(1);
                            shreg <= shift_in;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sdadc_serial_if.sv
module sdadc_serial_if
    import sdadc_pkg::*;
#(
    parameter int                 ONES_N   = 32,
    parameter logic [7:0]         ID_VAL   = 8'h4B,
    parameter logic [SD_MID-1:0]  MODE_RST = 16'h400A,
    parameter logic [SD_MID-1:0]  CONF_RST = 16'h0710,
    parameter logic [7:0]         IO_RST   = 8'h00,
    parameter logic [SD_WIDE-1:0] OFFS_RST = 24'h800000,
    parameter logic [SD_WIDE-1:0] FS_RST   = 24'h500000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_stb,
    input  logic               sdi,
    output logic               sdo,
    input  logic               conv_done,
    input  logic [SD_WIDE-1:0] conv_data,
    input  logic               conv_err,
    input  logic [SD_CH_W-1:0] conv_chan,
    output logic [SD_MID-1:0]  mode_word,
    output logic [SD_MID-1:0]  conf_word
);
    logic               if_reset;
    logic               rdy_n;
    logic [SD_WIDE-1:0] rd_value;
    reg_addr_e          rd_addr;
    logic               wr_en;
    reg_addr_e          wr_addr;
    logic [SD_WIDE-1:0] wr_data;
    logic               data_taken;
    logic               rd_active;
    logic               cread_on;
    conv_t              conv_in;

    assign conv_in = '{data: conv_data, err: conv_err, chan: conv_chan};

    sdadc_ones_det #(.ONES_N(ONES_N)) u_ones (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bit_stb),
        .sdi     (sdi),
        .hit     (if_reset)
    );

    sdadc_cmd_parser u_parser (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .sdi        (sdi),
        .if_reset   (if_reset),
        .rdy_n      (rdy_n),
        .rd_value   (rd_value),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .data_taken (data_taken),
        .sdo        (sdo),
        .rd_active  (rd_active),
        .cread_on   (cread_on)
    );

    sdadc_regfile #(
        .ID_VAL   (ID_VAL),
        .MODE_RST (MODE_RST),
        .CONF_RST (CONF_RST),
        .IO_RST   (IO_RST),
        .OFFS_RST (OFFS_RST),
        .FS_RST   (FS_RST)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_value   (rd_value),
        .data_taken (data_taken),
        .conv_done  (conv_done),
        .conv_in    (conv_in),
        .rdy_n      (rdy_n),
        .mode_q     (mode_word),
        .conf_q     (conf_word)
    );
endmodule

// File: rtl/sdadc_serial_if_chk.sv
module sdadc_serial_if_chk
    import sdadc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sdo,
    input logic              conv_done,
    input logic [SD_MID-1:0] mode_word,
    input logic              rdy_n,
    input logic              wr_en,
    input reg_addr_e         wr_addr,
    input logic              data_taken,
    input logic              if_reset,
    input logic              rd_active,
    input logic              cread_on
);
    logic [2:0] sel;
    assign sel = mode_word[15:13];

    assert_conv_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (conv_done && (sel == 3'd0 || sel == 3'd1)) |=> !rdy_n);

    assert_conv_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (conv_done && sel > 3'd1 && rdy_n) |=> rdy_n);

    assert_single_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (conv_done && sel == 3'd1 && !wr_en) |=> (mode_word[15:13] == 3'd2));

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (data_taken && !(conv_done && (sel == 3'd0 || sel == 3'd1))) |=> rdy_n);

    assert_sdo_ready_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_active |-> (sdo == rdy_n));

    assert_wr_legal_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !(wr_addr == A_STAT || wr_addr == A_DATA || wr_addr == A_IDENT));

    assert_if_reset_R12: assert property (@(posedge clk) disable iff (rst)
        if_reset |=> (!rd_active && !cread_on));
endmodule

bind sdadc_serial_if sdadc_serial_if_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sdo        (sdo),
    .conv_done  (conv_done),
    .mode_word  (mode_word),
    .rdy_n      (rdy_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .data_taken (data_taken),
    .if_reset   (if_reset),
    .rd_active  (rd_active),
    .cread_on   (cread_on)
);

// File: tb/sdadc_serial_if_tb_top.sv
module sdadc_serial_if_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_stb = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        conv_done = 1'b0;
    logic [23:0] conv_data = '0;
    logic        conv_err = 1'b0;
    logic [2:0]  conv_chan = '0;
    logic [15:0] mode_word;
    logic [15:0] conf_word;

    always #5 clk = ~clk;

    sdadc_serial_if dut_i (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .sdi       (sdi),
        .sdo       (sdo),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .conv_err  (conv_err),
        .conv_chan (conv_chan),
        .mode_word (mode_word),
        .conf_word (conf_word)
    );

    typedef struct {
        string       tag;
        logic [23:0] val;
    } item_t;

    item_t exp_q[$];
    item_t obs_q[$];
    int    n_cmp  = 0;
    int    n_fail = 0;
    bit    ended  = 1'b0;

    // monitor: compares observed items against expectations in order
    initial begin
        forever begin
            @(posedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                item_t e;
                item_t o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                n_cmp++;
                if (o.val !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, o.val, e.val);
                end
            end
        end
    end

    task automatic expect_val(input string tag, input logic [23:0] v);
        exp_q.push_back('{tag: tag, val: v});
    endtask

    task automatic observe(input string tag, input logic [23:0] v);
        obs_q.push_back('{tag: tag, val: v});
    endtask

    task automatic shift_bits(input logic [23:0] tx, input int n, output logic [23:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            rx[i]   = sdo;
            sdi     = tx[i];
            bit_stb = 1'b1;
        end
        @(negedge clk);
        bit_stb = 1'b0;
        sdi     = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        logic [23:0] dummy;
        shift_bits({16'h0, c}, 8, dummy);
    endtask

    task automatic read_reg(input string tag, input logic [7:0] c, input int n,
                            input logic [23:0] ev);
        logic [23:0] rx;
        expect_val(tag, ev);
        send_cmd(c);
        shift_bits(24'h0, n, rx);
        observe(tag, rx);
    endtask

    task automatic write_reg(input logic [7:0] c, input int n, input logic [23:0] d);
        logic [23:0] dummy;
        send_cmd(c);
        shift_bits(d, n, dummy);
    endtask

    task automatic check_sdo(input string tag, input logic ev);
        expect_val(tag, {23'h0, ev});
        observe(tag, {23'h0, sdo});
    endtask

    task automatic pulse_conv(input logic [23:0] d, input logic e, input logic [2:0] ch);
        @(negedge clk);
        conv_done = 1'b1;
        conv_data = d;
        conv_err  = e;
        conv_chan = ch;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (R1..R12 flow): actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [23:0] junk;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check_sdo("R10 ready high after reset", 1'b1);
        read_reg("R6 status after reset", 8'h40, 8, 24'h000080);
        read_reg("R5 id code", 8'h60, 8, 24'h00004B);
        read_reg("R3 mode reset", 8'h48, 16, 24'h00400A);
        read_reg("R3 conf reset", 8'h50, 16, 24'h000710);
        read_reg("R3 io reset", 8'h68, 8, 24'h000000);
        read_reg("R3 offset reset", 8'h70, 24, 24'h800000);
        read_reg("R3 fullscale reset", 8'h78, 24, 24'h500000);

        // writes of each width, MSB first
        write_reg(8'h10, 16, 24'h001234);
        read_reg("R2 R3 conf write", 8'h50, 16, 24'h001234);
        write_reg(8'h28, 8, 24'h0000A5);
        read_reg("R2 R3 io write", 8'h68, 8, 24'h0000A5);
        write_reg(8'h30, 24, 24'hABCDEF);
        read_reg("R2 R3 offset write", 8'h70, 24, 24'hABCDEF);
        write_reg(8'h38, 24, 24'h0F0F0F);
        read_reg("R2 R3 fullscale write", 8'h78, 24, 24'h0F0F0F);

        // read-only write attempts: no data phase, next byte is a command
        send_cmd(8'h20);
        read_reg("R4 id write ignored", 8'h60, 8, 24'h00004B);
        send_cmd(8'h18);
        read_reg("R4 data write ignored", 8'h48, 16, 24'h00400A);
        send_cmd(8'h00);
        read_reg("R4 status write ignored", 8'h50, 16, 24'h001234);

        // rejected command byte and cread bit on another address
        send_cmd(8'hC8);
        read_reg("R1 bit7 byte discarded", 8'h48, 16, 24'h00400A);
        read_reg("R1 cread bit ignored on mode", 8'h4C, 16, 24'h00400A);

        // conversion ignored in idle
        pulse_conv(24'h999999, 1'b1, 3'd7);
        check_sdo("R7 idle conversion ignored", 1'b1);
        read_reg("R7 status unchanged in idle", 8'h40, 8, 24'h000080);

        // continuous mode conversion
        write_reg(8'h08, 16, 24'h00000A);
        pulse_conv(24'h123456, 1'b1, 3'd5);
        check_sdo("R7 R10 ready low after conversion", 1'b0);
        read_reg("R6 status with error and channel", 8'h40, 8, 24'h000045);
        check_sdo("R9 status read keeps ready low", 1'b0);
        read_reg("R7 data latched", 8'h58, 24, 24'h123456);
        check_sdo("R9 ready released after data read", 1'b1);

        // single conversion returns to idle
        write_reg(8'h08, 16, 24'h00200A);
        pulse_conv(24'h00ABCD, 1'b0, 3'd2);
        read_reg("R8 single mode back to idle", 8'h48, 16, 24'h00400A);
        read_reg("R6 status single", 8'h40, 8, 24'h000002);
        read_reg("R7 single data", 8'h58, 24, 24'h00ABCD);

        // continuous read
        write_reg(8'h08, 16, 24'h00000A);
        send_cmd(8'h5C);
        pulse_conv(24'h111111, 1'b0, 3'd0);
        @(negedge clk);
        expect_val("R11 first streamed sample", 24'h111111);
        shift_bits(24'h0, 24, junk);
        observe("R11 first streamed sample", junk);
        check_sdo("R11 R9 ready high after stream", 1'b1);
        pulse_conv(24'h222222, 1'b0, 3'd1);
        @(negedge clk);
        expect_val("R11 second streamed sample", 24'h222222);
        shift_bits(24'h0, 24, junk);
        observe("R11 second streamed sample", junk);
        send_cmd(8'h58);
        pulse_conv(24'h333333, 1'b0, 3'd0);
        @(negedge clk);
        read_reg("R11 exit stops streaming", 8'h40, 8, 24'h000000);
        read_reg("R11 data after exit", 8'h58, 24, 24'h333333);

        // serial interface reset ends continuous read
        send_cmd(8'h5C);
        shift_bits(24'h00FFFF, 16, junk);
        shift_bits(24'h00FFFF, 16, junk);
        pulse_conv(24'h444444, 1'b0, 3'd3);
        @(negedge clk);
        read_reg("R12 reset left continuous read", 8'h40, 8, 24'h000003);
        read_reg("R12 data after reset", 8'h58, 24, 24'h444444);
        read_reg("R12 registers kept", 8'h50, 16, 24'h001234);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard drain (R1..R12 flow): actual=%0d left expected=0",
                     exp_q.size());
        end
        finish_run();
    end
endmodule